// File: doc/BRIEF.md
# Snooping Write-Back Coherence Controller

This block keeps a small direct-mapped cache of single-word lines coherent with other caches that share one broadcast bus. Each line carries a tag and one of three states: Invalid, Shared (clean, read-only) or Exclusive (sole copy, writable, dirty). Processor reads and writes that hit complete at once with no bus traffic. A miss blocks the processor. The controller then asks for the bus and, once it holds the grant, writes back a dirty victim if there is one. It then announces a read miss or a write miss and fills the line from the memory response. A write to a Shared line counts as a write miss.

Alongside the processor side, a snoop side watches the misses issued by other caches. It compares the snooped address with the stored tag in the same cycle. When it holds the line Exclusive, it supplies the dirty data in place of memory. It then downgrades or invalidates its own copy. A snoop that hits the line a blocked processor request is waiting on is handled first, and the request is then looked up again from scratch.

Top module: `coh_cache`

## Requirements
- R1: After reset every line is Invalid and `cpu_ready`, `bus_req`, `bus_valid` and `snp_wb` are low. The first access to any address is a miss.
- R2: A processor read of an Invalid line issues a read miss (`bus_cmd` = 1) and fills the line Shared. The read then returns the memory word.
- R3: A processor write to an Invalid or Shared line issues a write miss (`bus_cmd` = 2) and leaves the line Exclusive. Later reads return the written word.
- R4: A miss whose victim line is Exclusive under another tag first issues a write-back (`bus_cmd` = 3) carrying the victim's address and data. The miss command follows in the very next cycle. A Shared victim is dropped without a write-back.
- R5: A snooped write miss to an address held Shared invalidates the line without supplying data.
- R6: A snooped read miss to a line held Exclusive raises `snp_wb` in the same cycle with the line's data and leaves the line Shared. A snooped write miss to an Exclusive line does the same but leaves it Invalid.
- R7: No bus command is driven before `bus_gnt`. A snoop hit on the line of a request waiting for grant causes the request to be looked up again, so a victim that the snoop made clean is no longer written back.
- R8: Read hits in Shared or Exclusive, and write hits in Exclusive, raise `cpu_ready` in the cycle of the request with no bus traffic.
- R9: When a snoop hits the same line as a processor access in the same cycle, the snoop takes effect first and the processor access is evaluated against the updated state.
- R10: `cpu_ready` is high only while `cpu_req` is high, and it stays low on a miss until the line has been filled.
- R11: A snooped read miss to a line held Shared neither supplies data nor changes the line, which still hits afterwards.

Index is `addr[IDXW-1:0]` and the tag is the remaining upper bits. Bus command codes: 0 none, 1 read miss, 2 write miss, 3 write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Processor word address |
| cpu_wdata | input | DW | Processor write data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | DW | Read data, valid with cpu_ready |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus granted to this cache |
| bus_valid | output | 1 | A bus command is driven this cycle |
| bus_cmd | output | 2 | Bus command code |
| bus_addr | output | AW | Bus command address |
| bus_data | output | DW | Write-back data |
| mem_ack | input | 1 | Memory fill response valid |
| mem_rdata | input | DW | Memory fill data |
| snp_valid | input | 1 | Another cache's command is on the bus |
| snp_cmd | input | 2 | Snooped command code |
| snp_addr | input | AW | Snooped address |
| snp_wb | output | 1 | This cache supplies the snooped line (memory access aborted) |
| snp_wb_data | output | DW | Supplied line data |

## Verification
The checker assumes that the processor holds address, direction and write data steady while a request waits for ready. It also assumes that `bus_gnt` is only given while `bus_req` is high and that `mem_ack` arrives only after this cache has issued a miss. No snooped command appears while this cache holds the grant, because the bus serialises masters. The bench keeps to this with a bus model that registers the grant from the request and answers only issued misses. Snoops are injected only while the cache is idle or while the grant is deliberately withheld, which is how the restart and same-cycle priority cases are reached.

// File: rtl/coh_pkg.sv
package coh_pkg;

   typedef enum logic [1:0] {
      LS_I = 2'd0,
      LS_S = 2'd1,
      LS_E = 2'd2
   } line_st_t;

   typedef enum logic [1:0] {
      BC_NONE   = 2'd0,
      BC_RDMISS = 2'd1,
      BC_WRMISS = 2'd2,
      BC_WBACK  = 2'd3
   } bus_cmd_t;

   typedef enum logic [2:0] {
      CS_IDLE,
      CS_ARB,
      CS_WB,
      CS_ISSUE,
      CS_WAIT
   } ctl_st_t;

endpackage

// File: rtl/coh_tag_array.sv
module coh_tag_array
   import coh_pkg::*;
#(
   parameter int AW   = 16,
   parameter int IDXW = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [IDXW-1:0]     a_idx,
   output line_st_t            a_st,
   output logic [AW-IDXW-1:0]  a_tag,
   input  logic [IDXW-1:0]     b_idx,
   output line_st_t            b_st,
   output logic [AW-IDXW-1:0]  b_tag,
   input  logic                cw_we,
   input  logic [IDXW-1:0]     cw_idx,
   input  line_st_t            cw_st,
   input  logic [AW-IDXW-1:0]  cw_tag,
   input  logic                sw_we,
   input  logic [IDXW-1:0]     sw_idx,
   input  line_st_t            sw_st
);
   localparam int NL = 1 << IDXW;
   localparam int TW = AW - IDXW;

   line_st_t        st_v  [NL];
   logic [TW-1:0]   tag_v [NL];

   for (genvar i = 0; i < NL; i++) begin : g_line
      line_st_t      st_q;
      logic [TW-1:0] tag_q;
      // the snoop port wins over the processor port on the same line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q  <= LS_I;
            tag_q <= '0;
         end else if (sw_we && sw_idx == IDXW'(i)) begin
            st_q <= sw_st;
         end else if (cw_we && cw_idx == IDXW'(i)) begin
            st_q  <= cw_st;
            tag_q <= cw_tag;
         end
      end
      assign st_v[i]  = st_q;
      assign tag_v[i] = tag_q;
   end

   assign a_st  = st_v[a_idx];
   assign a_tag = tag_v[a_idx];
   assign b_st  = st_v[b_idx];
   assign b_tag = tag_v[b_idx];

endmodule

// File: rtl/coh_data_store.sv
module coh_data_store #(
   parameter int IDXW      = 3,
   parameter int DW        = 32,
   parameter bit ZERO_INIT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [IDXW-1:0] widx,
   input  logic [DW-1:0]   wdata,
   input  logic [IDXW-1:0] a_idx,
   output logic [DW-1:0]   a_data,
   input  logic [IDXW-1:0] b_idx,
   output logic [DW-1:0]   b_data
);
   localparam int NL = 1 << IDXW;

   logic [DW-1:0] mem_q [NL];

   generate
      if (ZERO_INIT) begin : g_zero
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < NL; i++) mem_q[i] <= '0;
            end else if (we) begin
               mem_q[widx] <= wdata;
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (we) mem_q[widx] <= wdata;
         end
      end
   endgenerate

   assign a_data = mem_q[a_idx];
   assign b_data = mem_q[b_idx];

endmodule

// File: rtl/coh_snoop.sv
module coh_snoop
   import coh_pkg::*;
#(
   parameter int AW   = 16,
   parameter int IDXW = 3
) (
   input  logic               snp_valid,
   input  logic [1:0]         snp_cmd,
   input  logic [AW-1:0]      snp_addr,
   input  line_st_t           line_st,
   input  logic [AW-IDXW-1:0] line_tag,
   output logic               hit,
   output logic               upd_we,
   output line_st_t           upd_st,
   output logic               supply
);
   logic is_rd, is_wr;

   assign is_rd = snp_cmd == BC_RDMISS;
   assign is_wr = snp_cmd == BC_WRMISS;
   assign hit   = snp_valid && (is_rd || is_wr) && line_st != LS_I
                  && line_tag == snp_addr[AW-1:IDXW];

   always_comb begin
      upd_we = 1'b0;
      upd_st = line_st;
      supply = 1'b0;
      if (hit) begin
         if (is_wr) begin
            upd_we = 1'b1;
            upd_st = LS_I;
            supply = line_st == LS_E;
         end else if (line_st == LS_E) begin
            upd_we = 1'b1;
            upd_st = LS_S;
            supply = 1'b1;
         end
      end
   end

endmodule

// File: rtl/coh_ctrl.sv
module coh_ctrl
   import coh_pkg::*;
#(
   parameter int AW   = 16,
   parameter int DW   = 32,
   parameter int IDXW = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_req,
   input  logic               cpu_we,
   input  logic [AW-1:0]      cpu_addr,
   input  logic [DW-1:0]      cpu_wdata,
   output logic               cpu_ready,
   input  line_st_t           line_st,
   input  logic [AW-IDXW-1:0] line_tag,
   input  logic [DW-1:0]      line_data,
   input  logic               snp_hit,
   input  logic [IDXW-1:0]    snp_idx,
   output logic               tw_we,
   output line_st_t           tw_st,
   output logic [AW-IDXW-1:0] tw_tag,
   output logic               dw_we,
   output logic [DW-1:0]      dw_data,
   output logic               bus_req,
   input  logic               bus_gnt,
   output logic               bus_valid,
   output logic [1:0]         bus_cmd,
   output logic [AW-1:0]      bus_addr,
   output logic [DW-1:0]      bus_data,
   input  logic               mem_ack,
   input  logic [DW-1:0]      mem_rdata
);
   ctl_st_t state_q, state_d;

   logic [IDXW-1:0]    idx;
   logic [AW-IDXW-1:0] ctag;
   logic               hit, conflict, victim_dirty;

   assign idx          = cpu_addr[IDXW-1:0];
   assign ctag         = cpu_addr[AW-1:IDXW];
   assign hit          = line_st != LS_I && line_tag == ctag;
   assign conflict     = snp_hit && snp_idx == idx;
   assign victim_dirty = line_st == LS_E && line_tag != ctag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= CS_IDLE;
      else        state_q <= state_d;
   end

   always_comb begin
      state_d   = state_q;
      cpu_ready = 1'b0;
      tw_we     = 1'b0;
      tw_st     = LS_I;
      tw_tag    = ctag;
      dw_we     = 1'b0;
      dw_data   = cpu_wdata;
      bus_req   = 1'b0;
      bus_valid = 1'b0;
      bus_cmd   = BC_NONE;
      bus_addr  = '0;
      bus_data  = '0;
      unique case (state_q)
         CS_IDLE: begin
            if (cpu_req && !conflict) begin
               if (hit && (!cpu_we || line_st == LS_E)) begin
                  cpu_ready = 1'b1;
                  dw_we     = cpu_we;
               end else begin
                  state_d = CS_ARB;
               end
            end
         end
         CS_ARB: begin
            bus_req = 1'b1;
            if (conflict)     state_d = CS_IDLE;
            else if (bus_gnt) state_d = victim_dirty ? CS_WB : CS_ISSUE;
         end
         CS_WB: begin
            bus_req   = 1'b1;
            bus_valid = 1'b1;
            bus_cmd   = BC_WBACK;
            bus_addr  = {line_tag, idx};
            bus_data  = line_data;
            tw_we     = 1'b1;
            tw_st     = LS_I;
            tw_tag    = line_tag;
            state_d   = CS_ISSUE;
         end
         CS_ISSUE: begin
            bus_req   = 1'b1;
            bus_valid = 1'b1;
            bus_cmd   = cpu_we ? BC_WRMISS : BC_RDMISS;
            bus_addr  = cpu_addr;
            state_d   = CS_WAIT;
         end
         CS_WAIT: begin
            bus_req = 1'b1;
            if (mem_ack) begin
               tw_we   = 1'b1;
               tw_st   = cpu_we ? LS_E : LS_S;
               dw_we   = 1'b1;
               dw_data = mem_rdata;
               state_d = CS_IDLE;
            end
         end
         default: state_d = CS_IDLE;
      endcase
   end

endmodule

// File: rtl/coh_cache.sv
module coh_cache
   import coh_pkg::*;
#(
   parameter int AW        = 16,
   parameter int DW        = 32,
   parameter int IDXW      = 3,
   parameter bit ZERO_INIT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_req,
   input  logic          cpu_we,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] cpu_wdata,
   output logic          cpu_ready,
   output logic [DW-1:0] cpu_rdata,
   output logic          bus_req,
   input  logic          bus_gnt,
   output logic          bus_valid,
   output logic [1:0]    bus_cmd,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_data,
   input  logic          mem_ack,
   input  logic [DW-1:0] mem_rdata,
   input  logic          snp_valid,
   input  logic [1:0]    snp_cmd,
   input  logic [AW-1:0] snp_addr,
   output logic          snp_wb,
   output logic [DW-1:0] snp_wb_data
);
   localparam int TW = AW - IDXW;

   generate
      if (IDXW < 1 || IDXW >= AW) begin : g_bad_idx
         $error("coh_cache: IDXW must be at least 1 and below AW");
      end
      if (DW < 1) begin : g_bad_dw
         $error("coh_cache: DW must be positive");
      end
   endgenerate

   line_st_t        a_st, b_st, cw_st, sw_st;
   logic [TW-1:0]   a_tag, b_tag, cw_tag;
   logic            cw_we, sw_we, dw_we, s_hit, s_supply;
   logic [DW-1:0]   dw_data, a_data, b_data;

   coh_tag_array #(.AW(AW), .IDXW(IDXW)) u_tags (
      .clk    (clk),
      .rst_n  (rst_n),
      .a_idx  (cpu_addr[IDXW-1:0]),
      .a_st   (a_st),
      .a_tag  (a_tag),
      .b_idx  (snp_addr[IDXW-1:0]),
      .b_st   (b_st),
      .b_tag  (b_tag),
      .cw_we  (cw_we),
      .cw_idx (cpu_addr[IDXW-1:0]),
      .cw_st  (cw_st),
      .cw_tag (cw_tag),
      .sw_we  (sw_we),
      .sw_idx (snp_addr[IDXW-1:0]),
      .sw_st  (sw_st)
   );

   coh_data_store #(.IDXW(IDXW), .DW(DW), .ZERO_INIT(ZERO_INIT)) u_data (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (dw_we),
      .widx   (cpu_addr[IDXW-1:0]),
      .wdata  (dw_data),
      .a_idx  (cpu_addr[IDXW-1:0]),
      .a_data (a_data),
      .b_idx  (snp_addr[IDXW-1:0]),
      .b_data (b_data)
   );

   coh_snoop #(.AW(AW), .IDXW(IDXW)) u_snoop (
      .snp_valid (snp_valid),
      .snp_cmd   (snp_cmd),
      .snp_addr  (snp_addr),
      .line_st   (b_st),
      .line_tag  (b_tag),
      .hit       (s_hit),
      .upd_we    (sw_we),
      .upd_st    (sw_st),
      .supply    (s_supply)
   );

   coh_ctrl #(.AW(AW), .DW(DW), .IDXW(IDXW)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_req   (cpu_req),
      .cpu_we    (cpu_we),
      .cpu_addr  (cpu_addr),
      .cpu_wdata (cpu_wdata),
      .cpu_ready (cpu_ready),
      .line_st   (a_st),
      .line_tag  (a_tag),
      .line_data (a_data),
      .snp_hit   (s_hit),
      .snp_idx   (snp_addr[IDXW-1:0]),
      .tw_we     (cw_we),
      .tw_st     (cw_st),
      .tw_tag    (cw_tag),
      .dw_we     (dw_we),
      .dw_data   (dw_data),
      .bus_req   (bus_req),
      .bus_gnt   (bus_gnt),
      .bus_valid (bus_valid),
      .bus_cmd   (bus_cmd),
      .bus_addr  (bus_addr),
      .bus_data  (bus_data),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata)
   );

   assign cpu_rdata   = a_data;
   assign snp_wb      = s_supply;
   assign snp_wb_data = s_supply ? b_data : '0;

endmodule

// File: rtl/coh_cache_chk.sv
module coh_cache_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cpu_req,
   input logic       cpu_ready,
   input logic       bus_req,
   input logic       bus_gnt,
   input logic       bus_valid,
   input logic [1:0] bus_cmd,
   input logic       snp_valid,
   input logic [1:0] snp_cmd,
   input logic       snp_wb
);
   // R7: a command is only driven while requesting and granted
   a_r7_cmd_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> (bus_gnt && bus_req));

   // R4: a victim write-back is followed at once by the miss command
   a_r4_wb_then_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_cmd == 2'd3) |=> (bus_valid && (bus_cmd == 2'd1 || bus_cmd == 2'd2)));

   // R4: a driven command is never the idle code
   a_r4_cmd_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> bus_cmd != 2'd0);

   // R6: data is supplied only in answer to a snooped miss
   a_r6_supply_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
      snp_wb |-> (snp_valid && (snp_cmd == 2'd1 || snp_cmd == 2'd2)));

   // R10: completion only under a live request
   a_r10_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> cpu_req);

   // R8: a completing access owns no bus transaction
   a_r8_ready_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> (!bus_req && !bus_valid));

endmodule

bind coh_cache coh_cache_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_req   (cpu_req),
   .cpu_ready (cpu_ready),
   .bus_req   (bus_req),
   .bus_gnt   (bus_gnt),
   .bus_valid (bus_valid),
   .bus_cmd   (bus_cmd),
   .snp_valid (snp_valid),
   .snp_cmd   (snp_cmd),
   .snp_wb    (snp_wb)
);

// File: tb/coh_cache_test.sv
module coh_cache_test;
   localparam int AW   = 16;
   localparam int DW   = 32;
   localparam int IDXW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic          cpu_ready;
   logic [DW-1:0] cpu_rdata;
   logic          bus_req, bus_valid;
   logic          bus_gnt = 1'b0;
   logic [1:0]    bus_cmd;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_data;
   logic          mem_ack = 1'b0;
   logic [DW-1:0] mem_rdata = '0;
   logic          snp_valid = 1'b0;
   logic [1:0]    snp_cmd = 2'd0;
   logic [AW-1:0] snp_addr = '0;
   logic          snp_wb;
   logic [DW-1:0] snp_wb_data;

   always #10 clk = ~clk;

   coh_cache #(.AW(AW), .DW(DW), .IDXW(IDXW)) uut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_cmd(bus_cmd),
      .bus_addr(bus_addr), .bus_data(bus_data),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
      .snp_wb(snp_wb), .snp_wb_data(snp_wb_data)
   );

   // kind: 0 bus command, 1 read result, 2 snoop-supplied data
   typedef struct packed {
      logic [1:0]    kind;
      logic [1:0]    cmd;
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
      logic [7:0]    rq;
   } ev_t;

   ev_t expq[$];
   int  vectors = 0;
   int  bad = 0;
   bit  gnt_en = 1'b1;
   bit  ended = 1'b0;

   task automatic chk(bit ok, int rq, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
      vectors++;
      if (!ok) begin
         bad++;
         $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic push(logic [1:0] kind, logic [1:0] cmd, logic [AW-1:0] a, logic [DW-1:0] d, int rq);
      ev_t e;
      e.kind = kind; e.cmd = cmd; e.addr = a; e.data = d; e.rq = 8'(rq);
      expq.push_back(e);
   endtask

   task automatic see(logic [1:0] kind, logic [1:0] cmd, logic [AW-1:0] a, logic [DW-1:0] d);
      ev_t e;
      if (expq.size() == 0) begin
         chk(1'b0, 0, $sformatf("unexpected event kind %0d cmd %0d addr %h", kind, cmd, a), d, '0);
      end else begin
         e = expq.pop_front();
         chk(e.kind == kind && e.cmd == cmd && e.addr == a, int'(e.rq),
             $sformatf("event kind %0d/%0d cmd %0d/%0d addr (actual,expected) data", kind, e.kind, cmd, e.cmd),
             DW'(a), DW'(e.addr));
         chk(e.data == d, int'(e.rq), "event data", d, e.data);
      end
   endtask

   // monitor: pops the scoreboard as results appear
   always @(negedge clk) begin
      if (rst_n) begin
         #2;
         if (bus_valid) see(2'd0, bus_cmd, bus_addr, bus_cmd == 2'd3 ? bus_data : '0);
         if (cpu_req && cpu_ready && !cpu_we) see(2'd1, 2'd0, cpu_addr, cpu_rdata);
         if (snp_valid && snp_wb) see(2'd2, 2'd0, snp_addr, snp_wb_data);
      end
   end

   // bus arbiter and memory model
   logic [DW-1:0] mem [256];
   int            pend = 0;
   logic [7:0]    paddr = '0;
   initial for (int i = 0; i < 256; i++) mem[i] = 32'h1000 + i;

   always @(posedge clk) begin
      mem_ack <= 1'b0;
      bus_gnt <= gnt_en && bus_req;
      if (bus_valid && bus_gnt) begin
         if (bus_cmd == 2'd3) mem[bus_addr[7:0]] <= bus_data;
         else begin
            pend  <= 3;
            paddr <= bus_addr[7:0];
         end
      end else if (pend > 1) begin
         pend <= pend - 1;
      end else if (pend == 1) begin
         pend      <= 0;
         mem_ack   <= 1'b1;
         mem_rdata <= mem[paddr];
      end
      if (snp_valid && snp_wb) mem[snp_addr[7:0]] <= snp_wb_data;
   end

   task automatic access(bit we, logic [AW-1:0] a, logic [DW-1:0] d, bit exp_hit, int rq);
      int n = 0;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      #1;
      chk(cpu_ready == exp_hit, rq, $sformatf("ready in request cycle, addr %h", a),
          DW'(cpu_ready), DW'(exp_hit));
      while (!cpu_ready && n < 300) begin
         @(negedge clk);
         #1;
         n++;
      end
      if (!cpu_ready) chk(1'b0, rq, "access never completed", '0, 1);
      @(negedge clk);
      cpu_req = 1'b0;
   endtask

   task automatic snoop(logic [1:0] cmd, logic [AW-1:0] a, bit exp_wb, int rq);
      @(negedge clk);
      snp_valid = 1'b1; snp_cmd = cmd; snp_addr = a;
      #1;
      chk(snp_wb == exp_wb, rq, $sformatf("snoop supply, addr %h", a), DW'(snp_wb), DW'(exp_wb));
      @(negedge clk);
      snp_valid = 1'b0; snp_cmd = 2'd0;
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      chk(1'b0, 0, "watchdog expired", '0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1: reset state at the ports
      chk(!cpu_ready && !bus_req && !bus_valid && !snp_wb, 1, "idle outputs after reset",
          DW'({cpu_ready, bus_req, bus_valid, snp_wb}), '0);

      // R1 R2: cold read misses, fills Shared
      push(0, 2'd1, 16'h0010, '0, 2); push(1, 0, 16'h0010, 32'h1010, 2);
      access(0, 16'h0010, '0, 0, 1);
      // R8: read hit in Shared, no bus traffic
      push(1, 0, 16'h0010, 32'h1010, 8);
      access(0, 16'h0010, '0, 1, 8);
      // R3: write to Shared is a write miss
      push(0, 2'd2, 16'h0010, '0, 3);
      access(1, 16'h0010, 32'hAAAA, 0, 3);
      push(1, 0, 16'h0010, 32'hAAAA, 3);
      access(0, 16'h0010, '0, 1, 3);
      // R8: write hit in Exclusive
      access(1, 16'h0010, 32'hBBBB, 1, 8);
      push(1, 0, 16'h0010, 32'hBBBB, 8);
      access(0, 16'h0010, '0, 1, 8);

      // R4: dirty victim written back before the read miss
      push(0, 2'd3, 16'h0010, 32'hBBBB, 4); push(0, 2'd1, 16'h0018, '0, 4);
      push(1, 0, 16'h0018, 32'h1018, 4);
      access(0, 16'h0018, '0, 0, 4);
      // R4: Shared victim dropped, memory holds the written-back word
      push(0, 2'd1, 16'h0010, '0, 4); push(1, 0, 16'h0010, 32'hBBBB, 4);
      access(0, 16'h0010, '0, 0, 4);

      // R3: write to Invalid
      push(0, 2'd2, 16'h0021, '0, 3);
      access(1, 16'h0021, 32'hCCCC, 0, 3);
      // R6: snooped read miss on Exclusive supplies data, line Shared
      push(2, 0, 16'h0021, 32'hCCCC, 6);
      snoop(2'd1, 16'h0021, 1, 6);
      push(1, 0, 16'h0021, 32'hCCCC, 6);
      access(0, 16'h0021, '0, 1, 6);
      // R11: snooped read miss on Shared changes nothing
      snoop(2'd1, 16'h0021, 0, 11);
      push(1, 0, 16'h0021, 32'hCCCC, 11);
      access(0, 16'h0021, '0, 1, 11);
      // R5: snooped write miss on Shared invalidates quietly
      snoop(2'd2, 16'h0021, 0, 5);
      push(0, 2'd1, 16'h0021, '0, 5); push(1, 0, 16'h0021, 32'hCCCC, 5);
      access(0, 16'h0021, '0, 0, 5);

      // R3 then R6: write miss from Shared, then snooped write miss on Exclusive
      push(0, 2'd2, 16'h0021, '0, 3);
      access(1, 16'h0021, 32'hDDDD, 0, 3);
      push(2, 0, 16'h0021, 32'hDDDD, 6);
      snoop(2'd2, 16'h0021, 1, 6);
      push(0, 2'd1, 16'h0021, '0, 6); push(1, 0, 16'h0021, 32'hDDDD, 6);
      access(0, 16'h0021, '0, 0, 6);

      // make 0x18 Exclusive in index 0
      push(0, 2'd2, 16'h0018, '0, 3);
      access(1, 16'h0018, 32'h5555, 0, 3);

      // R7: grant withheld, snoop cleans the victim, request restarts without write-back
      gnt_en = 1'b0;
      push(2, 0, 16'h0018, 32'h5555, 7); push(0, 2'd2, 16'h0028, '0, 7);
      fork
         access(1, 16'h0028, 32'h7777, 0, 7);
         begin
            repeat (3) @(negedge clk);
            snoop(2'd1, 16'h0018, 1, 7);
            gnt_en = 1'b1;
         end
      join
      push(1, 0, 16'h0028, 32'h7777, 7);
      access(0, 16'h0028, '0, 1, 7);

      // R9: same-cycle snoop on the line being written wins
      push(2, 0, 16'h0028, 32'h7777, 9); push(0, 2'd2, 16'h0028, '0, 9);
      fork
         access(1, 16'h0028, 32'h9999, 0, 9);
         snoop(2'd2, 16'h0028, 1, 9);
      join
      // R10 R4: dirty 0x28 written back, 0x18 read from memory
      push(0, 2'd3, 16'h0028, 32'h9999, 4); push(0, 2'd1, 16'h0018, '0, 4);
      push(1, 0, 16'h0018, 32'h5555, 10);
      access(0, 16'h0018, '0, 0, 10);
      push(0, 2'd1, 16'h0028, '0, 9); push(1, 0, 16'h0028, 32'h9999, 9);
      access(0, 16'h0028, '0, 0, 9);

      repeat (4) @(negedge clk);
      chk(expq.size() == 0, 10, "scoreboard drained", DW'(expq.size()), '0);
      finish_run();
   end

endmodule